// File: doc/BRIEF.md
# Free-Running 16-Bit Timer Counter with Prescaler

The block is the counting core of a small microcontroller timer. A 16-bit up-counter advances once per count-enable pulse. The pulse comes either from a free-running prescaler on the CPU clock (divide by 2, 4 or 8) or from rising edges of an external clock pin, which are synchronized into the CPU clock domain. The counter never reloads to zero. Reset and any software write to a low-byte register put it at FFFCh.

The CPU reaches the block over an 8-bit register bus. Reads have no wait state: `bus_rdata` follows `bus_addr` in the same cycle, and the side effects of a read or write take place at the clock edge that ends the access. The count can be read through two byte pairs, a main pair and an alternate pair. Reading a high byte freezes the matching low byte, so a high-then-low read gives a coherent 16-bit value. An overflow flag records each FFFFh to 0000h rollover. Only the main pair takes part in clearing that flag: software reads the status register while the flag is set, then reads the main low byte. The flag, gated by an enable bit, drives a single interrupt-request output.

A three-state machine keeps track of the flag:
- FL_CLEAR: no overflow is pending. It moves to FL_SET on a rollover.
- FL_SET: an overflow is pending and the clear sequence has not started. It moves to FL_ARMED on a status read. A rollover keeps it in FL_SET.
- FL_ARMED: the status register has been read while the flag was set. It moves to FL_CLEAR on a main low-byte read. A rollover sends it back to FL_SET, and a rollover takes priority over the clearing read.

Top module: `frt_timer`

## Requirements
- R1: After reset the count is FFFCh, the overflow flag reads 0, the control register reads 00h and `ovf_irq` is low.
- R2: The register addresses are: 0 main high byte, 1 main low byte, 2 alternate high byte, 3 alternate low byte, 4 status (bit 7 = overflow flag, all other bits read 0), 5 control (bits 1:0 = clock select, bit 7 = overflow interrupt enable, all other bits read 0). Both byte pairs return the same count.
- R3: A read of either high-byte register stores the low byte of the count at that moment. The next read of either low-byte register returns that stored byte. Any later low-byte read returns the live low byte.
- R4: A write to address 1 or 3 loads FFFCh into the counter whatever the data. In the same cycle, this load takes priority over a count step.
- R5: Writes to the high-byte registers (addresses 0 and 2) leave the count unchanged.
- R6: The clock select encodes 00 = CPU clock / 2, 01 = CPU clock / 4, 10 = CPU clock / 8, 11 = external clock. With an internal source the count advances exactly once per N CPU cycles, so the sequence repeats every 65536·N cycles (131072, 262144 or 524288). A new selection takes effect from the next count-enable pulse.
- R7: In external mode each rising edge of `ext_clk` advances the count by one, at the third CPU clock edge after the rise (two synchronizer flops plus an edge register). While `ext_clk` is static the count does not move.
- R8: The overflow flag sets on the step from FFFFh to 0000h.
- R9: The flag clears only when a main low-byte read (address 1) follows a status read that returned the flag set. Reads of the alternate low byte (address 3) neither clear the flag nor cancel a pending clear, and a main low-byte read without that status read leaves the flag set.
- R10: If a rollover falls in the same cycle as the clearing main low-byte read, the flag stays set and the clear sequence must begin again with a new status read.
- R11: `ovf_irq` is high exactly while the overflow flag is set and the interrupt enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe; side effects at the end of the cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, valid in the same cycle |
| ext_clk | input | 1 | External count clock, asynchronous to clk |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Two functions can fall in the same cycle. A counter rollover can coincide with the main low-byte read that would clear the flag, and a count step can coincide with a software reload. Both are provoked in external-clock mode by raising `ext_clk` exactly two cycles before the bus access, so that the synchronized edge arrives in the cycle of the read or write. The bench then judges the first case from `ovf_irq` and the status register: the flag must stay set and must need a new status read. It judges the second case from a 16-bit read that must return exactly FFFCh.

// File: rtl/frt_timer_pkg.sv
package frt_timer_pkg;

    typedef enum logic [2:0] {
        A_CNT_HI = 3'd0,
        A_CNT_LO = 3'd1,
        A_ALT_HI = 3'd2,
        A_ALT_LO = 3'd3,
        A_STAT   = 3'd4,
        A_CTRL   = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        CS_DIV2 = 2'b00,
        CS_DIV4 = 2'b01,
        CS_DIV8 = 2'b10,
        CS_EXT  = 2'b11
    } clksel_e;

    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_SET   = 2'd1,
        FL_ARMED = 2'd2
    } flag_state_e;

endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler
    import frt_timer_pkg::*;
#(
    parameter int PRE_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  clksel_e sel,
    input  logic    ext_clk,
    output logic    step
);

    logic [PRE_W-1:0]     pre_q;
    logic [SYNC_STAGES:0] sync_q;
    logic                 ext_rise;
    logic [2:0]           div_tick;

    // Free-running divider; it never restarts, so changing the selection cannot glitch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Each tap fires once every 2^(k+1) cycles.
    for (genvar k = 0; k < 3; k++) begin : g_tap
        assign div_tick[k] = &pre_q[k:0];
    end

    // Synchronizer flops followed by one more stage for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    always_comb begin
        unique case (sel)
            CS_DIV2: step = div_tick[0];
            CS_DIV4: step = div_tick[1];
            CS_DIV8: step = div_tick[2];
            CS_EXT:  step = ext_rise;
            default: step = 1'b0;
        endcase
    end

endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int          CNT_W      = 16,
    parameter logic [15:0] RELOAD_VAL = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             reload,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(RELOAD_VAL);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= LOAD;
        else if (reload) cnt_q <= LOAD;
        else if (step)   cnt_q <= cnt_q + 1'b1;
    end

    assign cnt  = cnt_q;
    assign wrap = step & ~reload & (&cnt_q);

endmodule

// File: rtl/frt_ovf_fsm.sv
module frt_ovf_fsm
    import frt_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic stat_rd,
    input  logic lo_rd,
    output logic flag
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: if (wrap) state_d = FL_SET;
            FL_SET: begin
                if (wrap)         state_d = FL_SET;
                else if (stat_rd) state_d = FL_ARMED;
            end
            FL_ARMED: begin
                if (wrap)       state_d = FL_SET;
                else if (lo_rd) state_d = FL_CLEAR;
            end
            default: state_d = FL_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FL_SET, FL_ARMED: flag = 1'b1;
            default:          flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/frt_timer.sv
module frt_timer
    import frt_timer_pkg::*;
#(
    parameter int          CNT_W       = 16,
    parameter int          DATA_W      = 8,
    parameter int          PRE_W       = 3,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] RELOAD_VAL  = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_clk,
    output logic              ovf_irq
);

    localparam int LO_W = CNT_W - DATA_W;

    clksel_e           sel_q;
    logic              ien_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              cnt_step;
    logic              cnt_reload;
    logic              cnt_wrap;
    logic              ovf_flag;
    logic [LO_W-1:0]   lo_buf_q;
    logic              lo_buf_vld_q;
    logic              hi_rd, lo_rd_any, lo_rd_main, stat_rd;
    logic [LO_W-1:0]   lo_view;
    logic              unused_wdata;

    assign hi_rd      = bus_rd & ((bus_addr == A_CNT_HI) | (bus_addr == A_ALT_HI));
    assign lo_rd_any  = bus_rd & ((bus_addr == A_CNT_LO) | (bus_addr == A_ALT_LO));
    assign lo_rd_main = bus_rd & (bus_addr == A_CNT_LO);
    assign stat_rd    = bus_rd & (bus_addr == A_STAT);
    assign cnt_reload = bus_wr & ((bus_addr == A_CNT_LO) | (bus_addr == A_ALT_LO));
    assign unused_wdata = ^bus_wdata[DATA_W-2:2];

    frt_prescaler #(
        .PRE_W      (PRE_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel_q),
        .ext_clk(ext_clk),
        .step   (cnt_step)
    );

    frt_counter #(
        .CNT_W     (CNT_W),
        .RELOAD_VAL(RELOAD_VAL)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (cnt_step),
        .reload(cnt_reload),
        .cnt   (cnt_q),
        .wrap  (cnt_wrap)
    );

    frt_ovf_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (cnt_wrap),
        .stat_rd(stat_rd),
        .lo_rd  (lo_rd_main),
        .flag   (ovf_flag)
    );

    // Control register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= CS_DIV2;
            ien_q <= 1'b0;
        end else if (bus_wr && bus_addr == A_CTRL) begin
            sel_q <= clksel_e'(bus_wdata[1:0]);
            ien_q <= bus_wdata[DATA_W-1];
        end
    end

    // Low-byte snapshot for coherent 16-bit reads.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_buf_q     <= '0;
            lo_buf_vld_q <= 1'b0;
        end else if (hi_rd) begin
            lo_buf_q     <= cnt_q[LO_W-1:0];
            lo_buf_vld_q <= 1'b1;
        end else if (lo_rd_any) begin
            lo_buf_vld_q <= 1'b0;
        end
    end

    assign lo_view = lo_buf_vld_q ? lo_buf_q : cnt_q[LO_W-1:0];

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CNT_HI, A_ALT_HI: bus_rdata = cnt_q[CNT_W-1:LO_W];
            A_CNT_LO, A_ALT_LO: bus_rdata = lo_view;
            A_STAT:             bus_rdata = {ovf_flag, {(DATA_W-1){1'b0}}};
            A_CTRL:             bus_rdata = {ien_q, {(DATA_W-3){1'b0}}, sel_q};
            default:            bus_rdata = '0;
        endcase
    end

    assign ovf_irq = ovf_flag & ien_q;

endmodule

// File: rtl/frt_timer_chk.sv
module frt_timer_chk #(
    parameter int          CNT_W      = 16,
    parameter logic [15:0] RELOAD_VAL = 16'hFFFC
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       bus_addr,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [CNT_W-1:0] cnt,
    input logic             reload,
    input logic             wrap,
    input logic             flag
);

    logic main_lo_rd;
    assign main_lo_rd = bus_rd && bus_addr == 3'd1;

    // R4: a low-byte write leaves FFFCh in the counter.
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 3'd1 || bus_addr == 3'd3)) |=> cnt == CNT_W'(RELOAD_VAL));

    // R6: apart from a reload, the count only moves by +1.
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cnt) && !$past(reload)) |-> cnt == $past(cnt) + 1'b1);

    // R8: a rollover sets the flag.
    a_r8_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag);

    // R9: the flag falls only after a main low-byte read.
    a_r9_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(main_lo_rd));

    // R10: without a main low-byte read the flag holds.
    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !main_lo_rd) |=> flag);

endmodule

bind frt_timer frt_timer_chk #(
    .CNT_W     (CNT_W),
    .RELOAD_VAL(RELOAD_VAL)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_addr(bus_addr),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .cnt     (cnt_q),
    .reload  (cnt_reload),
    .wrap    (cnt_wrap),
    .flag    (ovf_flag)
);

// File: tb/tb_frt_timer.sv
`timescale 1ns/1ps
module tb_frt_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic       ovf_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    frt_timer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ext_clk  (ext_clk),
        .ovf_irq  (ovf_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Each access starts at a negedge and ends at the next negedge.
    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read16(input logic [2:0] hi_a, output logic [15:0] v);
        logic [7:0] h, l;
        rd(hi_a, h);
        rd(hi_a + 3'd1, l);
        v = {h, l};
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1; repeat (4) @(negedge clk);
            ext_clk = 1'b0; repeat (4) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk(ovf_irq == 1'b0, "R1 irq", ovf_irq, 0);
        rd(3'd0, d); chk(d == 8'hFF, "R1 count high", d, 8'hFF);
        rd(3'd1, d); chk(d == 8'hFC || d == 8'hFD, "R1 count low", d, 8'hFC);
        rd(3'd4, d); chk(d == 8'h00, "R1 status", d, 0);
        rd(3'd5, d); chk(d == 8'h00, "R1 control", d, 0);
    endtask

    task automatic t_reload;
        logic [15:0] v;
        wr(3'd5, 8'h03);                    // external mode, irq disabled
        wr(3'd1, 8'h5A);
        read16(3'd0, v); chk(v == 16'hFFFC, "R4 main low write", v, 16'hFFFC);
        repeat (40) @(negedge clk);
        read16(3'd0, v); chk(v == 16'hFFFC, "R7 static ext_clk", v, 16'hFFFC);
        ext_pulses(3);
        read16(3'd0, v); chk(v == 16'hFFFF, "R7 three edges", v, 16'hFFFF);
        wr(3'd0, 8'h12); wr(3'd2, 8'h34);
        read16(3'd0, v); chk(v == 16'hFFFF, "R5 high writes ignored", v, 16'hFFFF);
        wr(3'd3, 8'h00);
        read16(3'd2, v); chk(v == 16'hFFFC, "R4 alt low write", v, 16'hFFFC);
    endtask

    task automatic t_reload_collision;
        logic [15:0] v;
        ext_clk = 1'b1;
        @(negedge clk); @(negedge clk);
        wr(3'd1, 8'hA5);                    // synchronized edge lands in this cycle
        ext_clk = 1'b0; repeat (4) @(negedge clk);
        read16(3'd0, v); chk(v == 16'hFFFC, "R4 reload beats step", v, 16'hFFFC);
    endtask

    task automatic t_views;
        logic [15:0] v, w;
        logic [7:0]  d;
        ext_pulses(2);
        read16(3'd0, v); read16(3'd2, w);
        chk(v == 16'hFFFE, "R2 main pair", v, 16'hFFFE);
        chk(w == 16'hFFFE, "R2 alt pair", w, 16'hFFFE);
        rd(3'd0, d);
        ext_pulses(3);                      // FFFE -> 0001, sets the flag
        rd(3'd1, d); chk(d == 8'hFE, "R3 latched low", d, 8'hFE);
        read16(3'd0, v); chk(v == 16'h0001, "R3 live after latch", v, 16'h0001);
        rd(3'd2, d);
        ext_pulses(1);
        rd(3'd3, d); chk(d == 8'h01, "R3 alt latched low", d, 8'h01);
    endtask

    task automatic t_flag;
        logic [7:0] d;
        chk(ovf_irq == 1'b0, "R11 irq masked", ovf_irq, 0);
        wr(3'd5, 8'h83);
        #1 chk(ovf_irq == 1'b1, "R11 irq enabled", ovf_irq, 1);
        rd(3'd1, d);                        // no status read first
        #1 chk(ovf_irq == 1'b1, "R9 unarmed main low read", ovf_irq, 1);
        rd(3'd4, d); chk(d == 8'h80, "R8 status flag set", d, 8'h80);
        rd(3'd3, d);
        #1 chk(ovf_irq == 1'b1, "R9 alt low read keeps flag", ovf_irq, 1);
        rd(3'd1, d);
        #1 chk(ovf_irq == 1'b0, "R9 clear sequence", ovf_irq, 0);
        rd(3'd4, d); chk(d == 8'h00, "R9 status cleared", d, 0);
    endtask

    task automatic t_clear_collision;
        logic [7:0]  d;
        logic [15:0] v;
        wr(3'd1, 8'h00);
        ext_pulses(4);                      // FFFC -> 0000
        rd(3'd4, d); chk(d == 8'h80, "R8 rollover sets flag", d, 8'h80);
        wr(3'd1, 8'h00);                    // still armed
        ext_pulses(3);                      // FFFF
        ext_clk = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(3'd1, d);                        // edge arrives with the clearing read
        ext_clk = 1'b0; repeat (4) @(negedge clk);
        #1 chk(ovf_irq == 1'b1, "R10 rollover beats clear", ovf_irq, 1);
        read16(3'd0, v); chk(v == 16'h0000, "R8 rolled to zero", v, 0);
        rd(3'd1, d);
        #1 chk(ovf_irq == 1'b1, "R10 re-arm needed", ovf_irq, 1);
        rd(3'd4, d); rd(3'd1, d);
        #1 chk(ovf_irq == 1'b0, "R10 cleared after re-arm", ovf_irq, 0);
    endtask

    task automatic t_divider(input logic [1:0] sel, input int n, input string tag);
        logic [15:0] a, b;
        wr(3'd5, {6'b0, sel});
        repeat (4) @(negedge clk);
        read16(3'd0, a);
        repeat (8 * n - 2) @(negedge clk);  // hi reads start 8*n cycles apart
        read16(3'd0, b);
        chk(16'(b - a) == 16'(8 * n / (1 << (sel + 1))) * 16'd1 ? 1'b1 : 1'b0, tag,
            16'(b - a), 8 * n / (1 << (sel + 1)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reload();
        t_reload_collision();
        t_views();
        t_flag();
        t_clear_collision();
        t_divider(2'b00, 25, "R6 divide by 2");
        t_divider(2'b01, 25, "R6 divide by 4");
        t_divider(2'b10, 25, "R6 divide by 8");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule